// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two matching timer/counters. Each one has a low byte, a high byte, a run bit and an overflow flag, and the two share one control register and one mode register. Each unit either counts machine-cycle ticks or counts falling edges on its own count pin. A gate option makes counting wait for a high level on the unit's gate pin, so the count measures how long a pulse stays high.

Four modes give a 13-bit counter with a 5-bit prescaler, a 16-bit counter, an 8-bit counter with auto-reload, and a split mode. In split mode timer 0's low byte and high byte run as two separate 8-bit counters. The high byte then takes over timer 1's run bit and overflow flag.

Each flag drives an interrupt request. The acknowledge pulse for that request clears the flag again. A host reaches the registers through a synchronous write port and a combinational read port.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous active-low reset, all six registers read 00h and both interrupt requests are low.
- R2: The register addresses are: 0 control, 1 mode, 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1. Control bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1. In the mode register, bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Within each nibble, bits [1:0] pick the mode (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 selects counting of pin edges, and bit 3 is the gate. A written value reads back unchanged.
- R3: In mode 0, low bits [4:0] act as a prescaler that carries into the full high byte. Low bits [7:5] never change. The flag is set when the count steps from high byte FFh with low bits 1Fh.
- R4: In mode 1, the high and low bytes form one 16-bit counter. The flag is set when the count wraps from FFFFh to 0000h.
- R5: In mode 2, only the low byte counts. When it steps from FFh it is loaded from the high byte and the flag is set. The high byte never changes.
- R6: When its run bit is 0, a unit (timer 0 outside split mode) does not count.
- R7: When the gate bit is 1, a unit counts only while its gate pin is high.
- R8: In counter mode, the count pin is sampled on each tick. The count advances by one on a tick whose sample is 0 when the previous sample was 1. Rising edges and a level that does not change do not count.
- R9: Each interrupt request equals its flag. An acknowledge clears the flag, but an overflow in the same cycle keeps it set.
- R10: In split mode, timer 0's low byte counts under run 0, gate 0 and counter select 0, and sets flag 0. Timer 0's high byte counts ticks while run 1 is set, and sets flag 1 when it wraps.
- R11: While timer 0 is in split mode, timer 1 counts in its own mode whatever its run bit says, and its wraps do not set flag 1.
- R12: With timer 1 in mode 3, timer 1's bytes hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Machine-cycle pulse, one clock wide |
| cnt_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | Gate inputs, one per unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq_ack | input | 2 | Acknowledge pulse per interrupt request |
| irq | output | 2 | Interrupt requests (overflow flags) |

## Verification
The hold, reload and flag-clear properties assume that no register write lands in the cycle they examine. Each antecedent therefore excludes `wr_en`. The properties also assume that `tick` is a single-cycle pulse and that the pins are already synchronous to `clk`. The stimulus follows these assumptions. Every write, tick and acknowledge lasts exactly one clock and is driven on the falling edge. Ticks never share a cycle with a write. Only the final flag test raises an acknowledge and a tick in the same cycle, on purpose.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared types and register addresses for the dual timer.
// Assumes a 3-bit register address space.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_13B   = 2'd0,
        MODE_16B   = 2'd1,
        MODE_8RLD  = 2'd2,
        MODE_SPLIT = 2'd3
    } tmr_mode_e;

    localparam logic [2:0] A_CTL  = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_LO0  = 3'd2;
    localparam logic [2:0] A_HI0  = 3'd3;
    localparam logic [2:0] A_LO1  = 3'd4;
    localparam logic [2:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
// Samples each count pin once per tick and flags a 1-then-0 pair of samples.
// Assumes the pins are already synchronous to clk.
module tmr_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] samp_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        // Hold the previous sample; refresh it only on a tick.
        always_ff @(posedge clk) begin
            if (!rst_n)    samp_q[g] <= 1'b0;
            else if (tick) samp_q[g] <= pin[g];
        end
        // A count is due when the last sample was 1 and this one is 0.
        assign fall[g] = tick & samp_q[g] & ~pin[g];
    end
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
// Next-state logic for one timer's byte pair in the four modes.
// Assumes at most one increment per cycle on each of the two paths.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PRE = 5
) (
    input  tmr_mode_e         mode,
    input  logic              inc_lo,
    input  logic              inc_hi,
    input  logic [DW-1:0]     lo,
    input  logic [DW-1:0]     hi,
    output logic [DW-1:0]     lo_n,
    output logic [DW-1:0]     hi_n,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    localparam logic [DW-1:0]  ALL1 = '1;
    localparam logic [PRE-1:0] PMAX = '1;

    // Work out the next byte values and any wrap for the selected mode.
    always_comb begin
        lo_n   = lo;
        hi_n   = hi;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            MODE_13B: if (inc_lo) begin
                lo_n[PRE-1:0] = lo[PRE-1:0] + 1'b1;
                if (lo[PRE-1:0] == PMAX) begin
                    hi_n   = hi + 1'b1;
                    ovf_lo = (hi == ALL1);
                end
            end
            MODE_16B: if (inc_lo) begin
                {hi_n, lo_n} = {hi, lo} + 1'b1;
                ovf_lo       = (hi == ALL1) && (lo == ALL1);
            end
            MODE_8RLD: if (inc_lo) begin
                if (lo == ALL1) begin
                    lo_n   = hi;
                    ovf_lo = 1'b1;
                end else begin
                    lo_n = lo + 1'b1;
                end
            end
            MODE_SPLIT: begin
                if (inc_lo) begin
                    lo_n   = lo + 1'b1;
                    ovf_lo = (lo == ALL1);
                end
                if (inc_hi) begin
                    hi_n   = hi + 1'b1;
                    ovf_hi = (hi == ALL1);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
// Two timer/counters with shared control and mode registers.
// Assumes tick is a one-clock pulse, pins are synchronous, and the reset is synchronous and active low.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PRE = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    cnt_pin,
    input  logic [1:0]    gate_pin,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [1:0]    irq_ack,
    output logic [1:0]    irq
);
    localparam int NU = 2;
    localparam int NB = 4;

    logic [1:0]              run_q, flag_q, set_flag, fall, gate_ok;
    logic [NU*NB-1:0]        mode_q;
    logic [NU-1:0][DW-1:0]   lo_q, hi_q, lo_n, hi_n;
    logic [NU-1:0]           inc_lo, inc_hi, ovf_lo, ovf_hi, is_ctr, is_gate;
    tmr_mode_e               mode_f [NU];
    logic                    split, wr_ctl;

    tmr_edge #(.N(NU)) u_edge (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin), .fall(fall)
    );

    for (genvar u = 0; u < NU; u++) begin : g_unit
        assign mode_f[u]  = tmr_mode_e'(mode_q[NB*u +: 2]);
        assign is_ctr[u]  = mode_q[NB*u + 2];
        assign is_gate[u] = mode_q[NB*u + 3];
        assign gate_ok[u] = ~is_gate[u] | gate_pin[u];

        tmr_unit #(.DW(DW), .PRE(PRE)) u_cnt (
            .mode(mode_f[u]), .inc_lo(inc_lo[u]), .inc_hi(inc_hi[u]),
            .lo(lo_q[u]), .hi(hi_q[u]), .lo_n(lo_n[u]), .hi_n(hi_n[u]),
            .ovf_lo(ovf_lo[u]), .ovf_hi(ovf_hi[u])
        );

        // Byte registers: a host write takes priority over counting.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[u] <= '0;
                hi_q[u] <= '0;
            end else begin
                lo_q[u] <= (wr_en && wr_addr == 3'(2 + 2*u)) ? wr_data : lo_n[u];
                hi_q[u] <= (wr_en && wr_addr == 3'(3 + 2*u)) ? wr_data : hi_n[u];
            end
        end

        // Flag: an overflow wins over a control write, which wins over an acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[u] <= 1'b0;
            else if (set_flag[u]) flag_q[u] <= 1'b1;
            else if (wr_ctl)      flag_q[u] <= wr_data[2+u];
            else if (irq_ack[u])  flag_q[u] <= 1'b0;
        end
    end

    assign split  = (mode_f[0] == MODE_SPLIT);
    assign wr_ctl = wr_en && (wr_addr == A_CTL);

    // Count enables: timer 0 low path, the split high path and timer 1.
    always_comb begin
        inc_lo[0] = run_q[0] & gate_ok[0] & (is_ctr[0] ? fall[0] : tick);
        inc_hi[0] = split & run_q[1] & tick;
        inc_lo[1] = (split | run_q[1]) & gate_ok[1] & (mode_f[1] != MODE_SPLIT)
                    & (is_ctr[1] ? fall[1] : tick);
        inc_hi[1] = 1'b0;
    end

    // Flag sources: in split mode timer 1's flag comes from timer 0's high byte.
    always_comb begin
        set_flag[0] = ovf_lo[0];
        set_flag[1] = split ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);
    end

    // Control and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTL)  run_q  <= wr_data[1:0];
            if (wr_addr == A_MODE) mode_q <= wr_data[NU*NB-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (rd_addr)
            A_CTL:   rd_data = {{(DW-4){1'b0}}, flag_q, run_q};
            A_MODE:  rd_data = DW'(mode_q);
            A_LO0:   rd_data = lo_q[0];
            A_HI0:   rd_data = hi_q[0];
            A_LO1:   rd_data = lo_q[1];
            A_HI1:   rd_data = hi_q[1];
            default: rd_data = '0;
        endcase
    end

    assign irq = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
// Property checker for tmr_pair, bound to every instance.
// Assumes writes and ticks come one clock at a time.
module tmr_pair_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    ack,
    input logic [1:0]    irq,
    input logic [1:0]    set_flag,
    input logic [7:0]    mode_q,
    input logic [1:0]    run_q,
    input logic          inc0,
    input logic [DW-1:0] lo0,
    input logic [DW-1:0] hi0,
    input logic [DW-1:0] lo1,
    input logic [DW-1:0] hi1
);
    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !wr_en && !set_flag[0]) |=> !irq[0]);

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'd2 && inc0 && lo0 == {DW{1'b1}} && !wr_en)
        |=> (lo0 == $past(hi0)) && irq[0]);

    // R5
    reload_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'd2 && !wr_en) |=> $stable(hi0));

    // R12
    t1_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5:4] == 2'd3 && !wr_en) |=> ($stable(lo1) && $stable(hi1)));

    // R6
    run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && mode_q[1:0] != 2'd3 && !wr_en) |=> ($stable(lo0) && $stable(hi0)));

    // R3
    prescale_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'd0 && !wr_en) |=> $stable(lo0[DW-1:5]));
endmodule

bind tmr_pair tmr_pair_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ack(irq_ack), .irq(irq),
    .set_flag(set_flag), .mode_q(mode_q), .run_q(run_q), .inc0(inc_lo[0]),
    .lo0(lo_q[0]), .hi0(hi_q[0]), .lo1(lo_q[1]), .hi1(hi_q[1])
);

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected reads, the monitor compares them.
module tmr_pair_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] irq_ack = '0;
    logic [1:0] irq;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    pend = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    tmr_pair u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq)
    );

    // Monitor: take each expected item, read it from the ports and compare.
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            wait (q.size() > 0);
            it = q.pop_front();
            if (it.sel < 6) rd_addr = 3'(it.sel);
            #1;
            act = (it.sel < 6) ? rd_data : {6'b0, irq};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
            end
            pend--;
        end
    end

    // Driver side: queue one expectation and wait until the monitor has checked it.
    task automatic chk(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        pend++;
        q.push_back(it);
        wait (pend == 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic ackp(input logic [1:0] m);
        @(negedge clk); irq_ack = m;
        @(negedge clk); irq_ack = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        for (int a = 0; a < 6; a++) chk(a, 8'h00, "R1 reset register");
        chk(6, 8'h00, "R1 reset irq");

        // R2 read back
        wr(3'd2, 8'h3C); chk(2, 8'h3C, "R2 low0 readback");
        wr(3'd5, 8'hC3); chk(5, 8'hC3, "R2 high1 readback");
        wr(3'd1, 8'hA6); chk(1, 8'hA6, "R2 mode readback");
        wr(3'd5, 8'h00);

        // R4 16-bit mode
        wr(3'd1, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h01);
        tk(1); chk(2, 8'hFF, "R4 low"); chk(3, 8'hFF, "R4 high"); chk(6, 8'h00, "R4 no flag");
        tk(1); chk(2, 8'h00, "R4 wrap low"); chk(3, 8'h00, "R4 wrap high");
        chk(6, 8'h01, "R4 flag"); chk(0, 8'h05, "R2 ctl flag bit");
        // R9 acknowledge
        ackp(2'b01); chk(6, 8'h00, "R9 ack clears");

        // R3 13-bit mode
        wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'h12);
        tk(1); chk(2, 8'hE0, "R3 prescale carry"); chk(3, 8'h13, "R3 high step");
        wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
        tk(1); chk(2, 8'h00, "R3 wrap low"); chk(3, 8'h00, "R3 wrap high"); chk(6, 8'h01, "R3 flag");
        ackp(2'b01);

        // R5 reload mode
        wr(3'd1, 8'h02); wr(3'd3, 8'hA5); wr(3'd2, 8'hFF);
        tk(1); chk(2, 8'hA5, "R5 reload"); chk(3, 8'hA5, "R5 high kept"); chk(6, 8'h01, "R5 flag");
        tk(1); chk(2, 8'hA6, "R5 after reload");
        ackp(2'b01);

        // R6 run off
        wr(3'd0, 8'h00); tk(3); chk(2, 8'hA6, "R6 held");

        // R7 gate
        wr(3'd1, 8'h09); wr(3'd0, 8'h01);
        gate_pin = 2'b00; tk(2); chk(2, 8'hA6, "R7 gate low holds");
        gate_pin = 2'b01; tk(2); chk(2, 8'hA8, "R7 gate high counts");

        // R8 counter mode
        wr(3'd1, 8'h05); wr(3'd2, 8'h00);
        cnt_pin[0] = 1'b1; tk(1); chk(2, 8'h00, "R8 rising ignored");
        cnt_pin[0] = 1'b0; repeat (2) @(negedge clk); chk(2, 8'h00, "R8 no tick no count");
        tk(1); chk(2, 8'h01, "R8 fall counted");
        tk(1); chk(2, 8'h01, "R8 steady low");
        cnt_pin[0] = 1'b1; tk(1); cnt_pin[0] = 1'b0; tk(1); chk(2, 8'h02, "R8 second fall");

        // R10 / R11 split mode
        wr(3'd1, 8'h13); wr(3'd2, 8'h00); wr(3'd3, 8'hFE); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        wr(3'd0, 8'h03);
        tk(1); chk(2, 8'h01, "R10 low0"); chk(3, 8'hFF, "R10 high0");
        chk(4, 8'h00, "R11 t1 wraps"); chk(6, 8'h00, "R11 t1 no flag");
        tk(1); chk(3, 8'h00, "R10 high0 wrap"); chk(6, 8'h02, "R10 flag1 from high0");
        wr(3'd0, 8'h01);
        tk(2); chk(3, 8'h00, "R10 run1 stops high0"); chk(2, 8'h04, "R10 low0 runs");
        chk(4, 8'h03, "R11 t1 ignores run1");

        // R12 timer 1 in mode 3
        wr(3'd1, 8'h31); wr(3'd0, 8'h02);
        tk(3); chk(4, 8'h03, "R12 low1 held"); chk(5, 8'h00, "R12 high1 held");

        // R9 overflow beats acknowledge
        wr(3'd1, 8'h10); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        tk(1); chk(6, 8'h02, "R9 flag1 set");
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        @(negedge clk); irq_ack = 2'b10; tick = 1'b1;
        @(negedge clk); irq_ack = 2'b00; tick = 1'b0;
        chk(6, 8'h02, "R9 overflow wins over ack");
        ackp(2'b10); chk(6, 8'h00, "R9 ack clears flag1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule